// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every received frame, whether the frame is kept, based only on its 48-bit destination address. The frame's destination address arrives on `daIn` together with a one-cycle strobe `daValid`. One cycle later the block returns a registered verdict on `accept`, and on `status` it gives flags that describe the address class. It compares the address against eight programmable exact-match entries, and each entry carries its own valid flag. The verdict also depends on four mode bits in a control word: accept everything, accept every multicast, refuse broadcast, and invert the exact-match result.

Software or a configuration engine loads the entries and the control word through a simple write port (`wrEn`, `wrAddr`, `wrData`). A write becomes effective on the clock edge that samples it. The address octet that travels first on the wire is `daIn[47:40]`, so its least significant bit, `daIn[40]`, is the group bit.

Top module: `rx_da_filter`

## Requirements
- R1: A write with `wrAddr` = 0 loads `wrData[7:0]` into the control word. A write with `wrAddr` = 16+2i loads `wrData` as address bits 31:0 of entry i. A write with `wrAddr` = 17+2i loads `wrData[15:0]` as address bits 47:32 of entry i and `wrData[16]` as that entry's valid flag. A write to any other address changes nothing.
- R2: `frameValid` is high in exactly the cycle after a cycle with `daValid` high. Whenever `frameValid` is low, `accept` and `status` are 0.
- R3: When no mode applies to the frame, it is accepted if and only if some entry with its valid flag set holds an address equal to `daIn`.
- R4: An entry whose valid flag is clear never matches. Reset clears every valid flag, and rewriting an entry's high word with bit 16 clear disables that entry.
- R5: With control bit 7 set, the exact-match result is inverted for frames that reach the exact-match stage: a hit rejects the frame and a non-hit accepts it.
- R6: With control bit 3 set, every frame is accepted. `status` bit 7 is set when the frame would have been rejected with bit 3 clear and the other bits unchanged; otherwise bit 7 is 0.
- R7: The all-ones address is broadcast. It sets `status` bit 6. When control bit 3 is clear, a broadcast frame is accepted if control bit 0 is clear and rejected if bit 0 is set, and the entries play no part.
- R8: A non-broadcast address with `daIn[40]` set is multicast and sets `status` bit 5. With control bit 1 set it is accepted. With bit 1 clear it is decided by the exact-match stage (R3, R5).
- R9: After reset, `frameValid`, `accept` and `status` are 0 and the control word is 0. `status` bits 4:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 5 | Configuration write address |
| wrData | input | 32 | Configuration write data |
| daValid | input | 1 | Destination address strobe |
| daIn | input | 48 | Destination address, first octet in bits 47:40 |
| frameValid | output | 1 | Verdict valid, one cycle after `daValid` |
| accept | output | 1 | 1 keeps the frame, 0 drops it |
| status | output | 8 | Bit 7 promiscuous-only accept, bit 6 broadcast, bit 5 multicast |

## Verification
Unicast addresses are sent against a loaded valid entry, an entry loaded with its valid flag clear, and no entry at all. This separates exact matching from the valid gating and from the reset state. The same unicast pair is then repeated under the inverted-match mode and under the promiscuous mode, alone and combined with inversion, so that an accept caused by a mode can be told apart from an accept caused by recognition through the miss flag. The broadcast and multicast addresses are sent under each mode bit that singles them out, and the multicast address is also loaded into an entry. Writes to an unmapped address and a write that clears an entry's valid flag are each followed by a frame whose verdict would change if that write had had an effect.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  parameter int ENTRY_CNT = 8;
  parameter int DA_W      = 48;
  parameter int DATA_W    = 32;
  localparam int IDX_W    = $clog2(ENTRY_CNT);
  localparam int ADDR_W   = IDX_W + 2;
  localparam int HI_W     = DA_W - DATA_W;
  localparam int VLD_BIT  = 16;

  // control word bit positions
  localparam int C_NOBC   = 0;
  localparam int C_ALLMC  = 1;
  localparam int C_PROM   = 3;
  localparam int C_INVHIT = 7;

  typedef struct packed {
    logic             loWe;
    logic             hiWe;
    logic [IDX_W-1:0] sel;
  } entryWrT;
endpackage

// File: rtl/rx_da_filter_dp.sv
module rx_da_filter_dp
  import rx_da_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  entryWrT           wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DA_W-1:0]   daIn,
  output logic              hit,
  output logic              isBcast,
  output logic              isMcast
);
  logic [ENTRY_CNT-1:0] matchVec;

  for (genvar i = 0; i < ENTRY_CNT; i++) begin : gEnt
    logic [DATA_W-1:0] entLo;
    logic [HI_W-1:0]   entHi;
    logic              entV;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entLo <= '0;
        entHi <= '0;
        entV  <= 1'b0;
      end else begin
        if (wrStb.loWe && wrStb.sel == IDX_W'(i)) entLo <= wrData;
        if (wrStb.hiWe && wrStb.sel == IDX_W'(i)) begin
          entHi <= wrData[HI_W-1:0];
          entV  <= wrData[VLD_BIT];
        end
      end
    end

    assign matchVec[i] = entV && ({entHi, entLo} == daIn);
  end

  always_comb begin
    hit     = |matchVec;
    isBcast = &daIn;
    isMcast = daIn[DA_W-8] && !isBcast;
  end
endmodule

// File: rtl/rx_da_filter_ctl.sv
module rx_da_filter_ctl
  import rx_da_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrCtl,
  input  logic              daValid,
  input  logic              hit,
  input  logic              isBcast,
  input  logic              isMcast,
  output entryWrT           wrStb,
  output logic [7:0]        ctrlWord,
  output logic              frameValid,
  output logic              accept,
  output logic [7:0]        status
);
  logic ctlSel, entSel, recogOk, keep, miss;

  always_comb begin
    ctlSel      = wrEn && (wrAddr == '0);
    entSel      = wrEn && wrAddr[ADDR_W-1];
    wrStb.sel   = wrAddr[IDX_W:1];
    wrStb.loWe  = entSel && !wrAddr[0];
    wrStb.hiWe  = entSel && wrAddr[0];
  end

  always_comb begin
    if (isBcast)                           recogOk = !ctrlWord[C_NOBC];
    else if (isMcast && ctrlWord[C_ALLMC]) recogOk = 1'b1;
    else                                   recogOk = hit ^ ctrlWord[C_INVHIT];
    keep = ctrlWord[C_PROM] || recogOk;
    miss = ctrlWord[C_PROM] && !recogOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord   <= '0;
      frameValid <= 1'b0;
      accept     <= 1'b0;
      status     <= '0;
    end else begin
      if (ctlSel) ctrlWord <= wrCtl;
      frameValid <= daValid;
      accept     <= daValid && keep;
      status     <= daValid ? {miss, isBcast, isMcast, 5'b0} : 8'h00;
    end
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        daValid,
  input  logic [47:0] daIn,
  output logic        frameValid,
  output logic        accept,
  output logic [7:0]  status
);
  entryWrT    wrStb;
  logic [7:0] ctrlWord;
  logic       hit, isBcast, isMcast;

  rx_da_filter_dp uDp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .daIn(daIn),
    .hit(hit), .isBcast(isBcast), .isMcast(isMcast)
  );

  rx_da_filter_ctl uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCtl(wrData[7:0]),
    .daValid(daValid), .hit(hit), .isBcast(isBcast), .isMcast(isMcast),
    .wrStb(wrStb), .ctrlWord(ctrlWord), .frameValid(frameValid),
    .accept(accept), .status(status)
  );
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        daValid,
  input logic [47:0] daIn,
  input logic [7:0]  ctrlWord,
  input logic        frameValid,
  input logic        accept,
  input logic [7:0]  status
);
  AST_VERDICT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    daValid |=> frameValid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> (!accept && status == 8'h00)); // R2
  AST_PROM_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (daValid && ctrlWord[3]) |=> accept); // R6
  AST_MISS_IMPLIES_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    status[7] |-> accept); // R6
  AST_BCAST_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (daValid && &daIn) |=> (status[6] && !status[5])); // R7
  AST_BCAST_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (daValid && &daIn && ctrlWord[0] && !ctrlWord[3]) |=> !accept); // R7
  AST_MCAST_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (daValid && daIn[40] && !(&daIn)) |=> (status[5] && !status[6])); // R8
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    status[4:0] == 5'b0); // R9
endmodule

bind rx_da_filter rx_da_filter_chk uChk (
  .clk(clk), .rstN(rstN), .daValid(daValid), .daIn(daIn), .ctrlWord(ctrlWord),
  .frameValid(frameValid), .accept(accept), .status(status)
);

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        daValid = 1'b0;
  logic [47:0] daIn = '0;
  logic        frameValid, accept;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {logic acc; logic [7:0] st; string req;} expT;
  expT expQ[$];

  logic [31:0] shLo [8];
  logic [15:0] shHi [8];
  logic        shV  [8];
  logic [7:0]  shCtl;

  localparam logic [47:0] ADR_A = 48'h0012_3456_789A;
  localparam logic [47:0] ADR_B = 48'h0022_4466_88AA;
  localparam logic [47:0] ADR_C = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] ADR_M = 48'h0100_5E00_0001;
  localparam logic [47:0] ADR_BC = 48'hFFFF_FFFF_FFFF;

  always #2 clk = ~clk;

  rx_da_filter dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .daValid(daValid), .daIn(daIn), .frameValid(frameValid), .accept(accept),
    .status(status)
  );

  function automatic expT model(input logic [47:0] a, input string req);
    expT e;
    logic bc, mc, hitM, rec;
    bc = &a;
    mc = a[40] && !bc;
    hitM = 1'b0;
    for (int i = 0; i < 8; i++)
      if (shV[i] && {shHi[i], shLo[i]} == a) hitM = 1'b1;
    if (bc) rec = !shCtl[0];
    else if (mc && shCtl[1]) rec = 1'b1;
    else rec = hitM ^ shCtl[7];
    e.acc = shCtl[3] || rec;
    e.st  = {shCtl[3] && !rec, bc, mc, 5'b0};
    e.req = req;
    return e;
  endfunction

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    if (a == 5'd0) shCtl = d[7:0];
    else if (a[4] && !a[0]) shLo[a[3:1]] = d;
    else if (a[4] && a[0]) begin shHi[a[3:1]] = d[15:0]; shV[a[3:1]] = d[16]; end
  endtask

  task automatic sendDa(input logic [47:0] a, input string req);
    @(posedge clk); #1;
    daValid = 1'b1; daIn = a;
    expQ.push_back(model(a, req));
    @(posedge clk); #1;
    daValid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && frameValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected verdict: actual frameValid=1 expected 0");
      end else begin
        expT e;
        e = expQ.pop_front();
        if (accept !== e.acc || status !== e.st) begin
          fails++;
          $display("FAIL %s accept/status actual %b/%h expected %b/%h",
                   e.req, accept, status, e.acc, e.st);
        end
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    shCtl = '0;
    for (int i = 0; i < 8; i++) begin shLo[i] = '0; shHi[i] = '0; shV[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checks++; // R9 reset state
    if (frameValid !== 1'b0 || accept !== 1'b0 || status !== 8'h00) begin
      fails++;
      $display("FAIL R9 reset outputs actual %b %b %h expected 0 0 00",
               frameValid, accept, status);
    end
    sendDa(ADR_A, "R4 no entry after reset");
    regWrite(5'd16, ADR_A[31:0]);                      // R1 entry 0 low
    regWrite(5'd17, {15'd0, 1'b1, ADR_A[47:32]});      // R1 entry 0 high valid
    regWrite(5'd18, ADR_B[31:0]);
    regWrite(5'd19, {15'd0, 1'b0, ADR_B[47:32]});      // entry 1 not valid
    sendDa(ADR_A, "R3 valid entry hit");
    sendDa(ADR_B, "R4 invalid entry");
    sendDa(ADR_C, "R3 no hit");
    // back-to-back frames
    @(posedge clk); #1;
    daValid = 1'b1; daIn = ADR_A; expQ.push_back(model(ADR_A, "R2 back-to-back 1"));
    @(posedge clk); #1;
    daIn = ADR_C; expQ.push_back(model(ADR_C, "R2 back-to-back 2"));
    @(posedge clk); #1;
    daValid = 1'b0;
    regWrite(5'd0, 32'h80);
    sendDa(ADR_A, "R5 inverted hit");
    sendDa(ADR_C, "R5 inverted miss");
    regWrite(5'd0, 32'h08);
    sendDa(ADR_C, "R6 prom with miss flag");
    sendDa(ADR_A, "R6 prom recognised");
    regWrite(5'd0, 32'h88);
    sendDa(ADR_A, "R6 prom with inversion");
    regWrite(5'd0, 32'h00);
    sendDa(ADR_BC, "R7 broadcast accepted");
    regWrite(5'd0, 32'h81);
    sendDa(ADR_BC, "R7 broadcast refused");
    regWrite(5'd0, 32'h09);
    sendDa(ADR_BC, "R7 broadcast under prom");
    regWrite(5'd0, 32'h00);
    sendDa(ADR_M, "R8 multicast no entry");
    regWrite(5'd0, 32'h02);
    sendDa(ADR_M, "R8 all-multicast");
    regWrite(5'd0, 32'h00);
    regWrite(5'd20, ADR_M[31:0]);
    regWrite(5'd21, {15'd0, 1'b1, ADR_M[47:32]});
    sendDa(ADR_M, "R8 multicast exact entry");
    // R1 unmapped writes change nothing
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = 5'd5; wrData = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    wrAddr = 5'd15;
    @(posedge clk); #1;
    wrEn = 1'b0;
    sendDa(ADR_C, "R1 unmapped write ignored");
    sendDa(ADR_A, "R1 entries intact");
    regWrite(5'd17, {15'd0, 1'b0, ADR_A[47:32]});
    sendDa(ADR_A, "R4 valid cleared");
    repeat (4) @(posedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2 missing verdicts actual %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule